// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block produces the auto-negotiation pulse bursts that a twisted-pair link sends to advertise its abilities. A 16-bit code word is converted into one burst. The burst interleaves 17 framing (clock) pulses with 16 bit slots. A slot carries a pulse only when its code word bit is 1, so a burst holds between 17 and 33 pulses. Bursts repeat at a fixed period for as long as the enable input is high.

All timing runs on a timebase `tick`, a single-cycle strobe in the fast clock domain. Every interval is a parameter counted in ticks. The defaults assume a 100 ns tick:

- `PULSE_TICKS` = 1, giving a pulse of about 100 ns.
- `HALF_TICKS` = 625, giving 62.5 µs from a clock pulse to its data pulse and 125 µs between clock pulses. A burst therefore spans about 2 ms.
- `BURST_TICKS` = 160000, giving one burst every 16 ms.

Parameters must satisfy `PULSE_TICKS < HALF_TICKS` and `BURST_TICKS > 33*HALF_TICKS`. Pulse shaping onto the wire belongs to the analog front end that follows.

Top module: `flp_burst_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pulse_out` and `burst_active` are 0.
- R2: A burst has 33 pulse positions numbered 0 to 32, each one half-slot apart. Every even position carries a clock pulse. Odd position 2i+1 carries a pulse exactly when code word bit i is 1, so bit 0 is sent first. A burst therefore contains 17 pulses plus one pulse for each 1 bit.
- R3: Every pulse of a burst rises a whole multiple of `HALF_TICKS` ticks after the first pulse of that burst.
- R4: Every pulse stays high for exactly `PULSE_TICKS` ticks. This includes a pulse that is still in progress when `enable` drops.
- R5: `burst_active` rises on the same clock edge as the first pulse of a burst. It stays high for exactly 33×`HALF_TICKS` ticks.
- R6: While `enable` stays high, consecutive bursts start exactly `BURST_TICKS` ticks apart.
- R7: The code word is captured on the edge where a burst starts. A change to `code_word` during a burst does not alter that burst.
- R8: When `enable` is sampled low, `burst_active` is 0 after that edge and no new pulse starts. When `enable` returns high with no pulse in flight, the next burst starts on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; all intervals advance only on cycles where it is high |
| enable | input | 1 | Keeps bursts repeating while high; aborts the current burst when low |
| code_word | input | 16 | Link code word to advertise, bit 0 sent first |
| pulse_out | output | 1 | Pulse train to the line driver |
| burst_active | output | 1 | High for the duration of a burst |

## Verification
The embedded assertions rely on two assumptions. First, the parameters leave a gap between bursts and make a pulse shorter than a half-slot. Second, `tick` is a plain synchronous strobe that may be high on any cycle. The bench keeps the parameters inside these limits. It drives `tick` high on a random three cycles in four, so pulse positions are checked in ticks and not in cycles. It re-enables only after the aborted pulse has finished, which the restart-timing requirement presupposes. Code word changes are timed both between bursts and in the middle of a burst.

// File: rtl/flp_pkg.sv
package flp_pkg;

    localparam int CW_BITS = 16;
    localparam int N_POS   = 2 * CW_BITS + 1;
    localparam int POS_W   = $clog2(N_POS);

    typedef enum logic { SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1 } seq_state_t;

    // Whether a given position in the burst carries a pulse.
    function automatic logic slot_fires(input logic [POS_W-1:0] pos,
                                        input logic [CW_BITS-1:0] word);
        if (pos[0])
            return word[pos[4:1]];
        return 1'b1;
    endfunction

endpackage

// File: rtl/flp_period_timer.sv
module flp_period_timer #(
    parameter int BURST_TICKS = 160000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enable,
    input  logic hold,
    output logic start
);
    localparam int CNT_W = $clog2(BURST_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign start = enable && tick && (cnt == '0) && !hold;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (tick && !((cnt == '0) && hold)) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flp_slot_seq.sv
module flp_slot_seq
    import flp_pkg::*;
#(
    parameter int HALF_TICKS = 625
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               enable,
    input  logic               start,
    input  logic [CW_BITS-1:0] code_word,
    output logic               fire,
    output logic               active
);
    localparam int HS_W = $clog2(HALF_TICKS);
    localparam logic [HS_W-1:0]  HS_LAST  = HS_W'(HALF_TICKS - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(N_POS - 1);

    seq_state_t         state;
    logic [POS_W-1:0]   pos;
    logic [HS_W-1:0]    hs;
    logic [CW_BITS-1:0] word_q;
    logic               slot_end;
    logic               begin_burst;

    assign active      = (state == SEQ_RUN);
    assign slot_end    = active && tick && (hs == HS_LAST);
    assign begin_burst = enable && start && !active;

    always_comb begin
        fire = 1'b0;
        if (enable) begin
            if (begin_burst)
                fire = 1'b1;
            else if (slot_end && (pos != POS_LAST))
                fire = slot_fires(pos + 1'b1, word_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            pos    <= '0;
            hs     <= '0;
            word_q <= '0;
        end else if (!enable) begin
            state <= SEQ_IDLE;
            pos   <= '0;
            hs    <= '0;
        end else if (begin_burst) begin
            state  <= SEQ_RUN;
            pos    <= '0;
            hs     <= '0;
            word_q <= code_word;
        end else if (active && tick) begin
            if (hs == HS_LAST) begin
                hs <= '0;
                if (pos == POS_LAST) begin
                    state <= SEQ_IDLE;
                    pos   <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end else begin
                hs <= hs + 1'b1;
            end
        end
    end

    // The captured word may change only on the edge that starts a burst.
    assert_word_held_R7: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(begin_burst)) |-> $stable(word_q));

endmodule

// File: rtl/flp_pulse_stretch.sv
module flp_pulse_stretch #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    output logic pulse
);
    localparam int W_W = $clog2(PULSE_TICKS + 1);

    logic [W_W-1:0] left;

    assign pulse = (left != '0);

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (fire)
            left <= W_W'(PULSE_TICKS);
        else if (tick && pulse)
            left <= left - 1'b1;
    end

    // A new pulse is requested only after the previous one has ended.
    assert_fire_when_low_R4: assert property (@(posedge clk) disable iff (rst)
        fire |-> !pulse);

endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen
    import flp_pkg::*;
#(
    parameter int PULSE_TICKS = 1,
    parameter int HALF_TICKS  = 625,
    parameter int BURST_TICKS = 160000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               enable,
    input  logic [CW_BITS-1:0] code_word,
    output logic               pulse_out,
    output logic               burst_active
);
    logic start;
    logic fire;
    logic hold;

    assign hold = pulse_out || burst_active;

    flp_period_timer #(.BURST_TICKS(BURST_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .enable (enable),
        .hold   (hold),
        .start  (start)
    );

    flp_slot_seq #(.HALF_TICKS(HALF_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .enable    (enable),
        .start     (start),
        .code_word (code_word),
        .fire      (fire),
        .active    (burst_active)
    );

    flp_pulse_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .fire  (fire),
        .pulse (pulse_out)
    );

    assert_pulse_in_burst_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> burst_active);

    assert_burst_opens_with_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_active) |-> $rose(pulse_out));

    assert_disable_stops_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !burst_active);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pulse_out && !burst_active));

endmodule

// File: tb/sim_flp_burst_gen.sv
module sim_flp_burst_gen;

    localparam int P  = 2;
    localparam int H  = 8;
    localparam int BT = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] code_word = 16'h0000;
    logic        pulse_out;
    logic        burst_active;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    flp_burst_gen #(.PULSE_TICKS(P), .HALF_TICKS(H), .BURST_TICKS(BT)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .enable(enable),
        .code_word(code_word), .pulse_out(pulse_out), .burst_active(burst_active)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [32:0] exp_mask(input logic [15:0] w);
        logic [32:0] m;
        for (int p = 0; p < 33; p++)
            m[p] = (p % 2 == 0) ? 1'b1 : w[(p - 1) / 2];
        return m;
    endfunction

    function automatic int ones(input logic [15:0] w);
        int n = 0;
        for (int i = 0; i < 16; i++) n += w[i];
        return n;
    endfunction

    // timebase: random strobe, three cycles in four on average
    initial begin
        void'($urandom(32'd20240611));
        forever begin
            @(posedge clk);
            #1 tick <= ($urandom % 4) != 0;
        end
    end

    // monitor state
    int          tcount = 0;
    logic        prev_pulse = 0, prev_act = 0, prev_en = 0;
    logic [15:0] prev_cw = 0, exp_word = 0;
    logic [32:0] mask = 0;
    int          burst_t0 = 0, npulses = 0, width = 0, act_ticks = 0;
    int          last_start = -1, ticks_at_en = 0;
    bit          aborted = 0, await_first = 0, mid_change = 0, mon_on = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            logic rise;
            rise = pulse_out && !prev_pulse;
            if (!prev_en) begin
                if (rise) check(0, "R8 pulse after disable", 1, 0);
                if (burst_active) check(0, "R8 active after disable", 1, 0);
            end
            if (enable && !prev_en) begin
                ticks_at_en = tcount;
                await_first = 1;
            end
            if (burst_active && !prev_act) begin
                exp_word  = prev_cw;
                burst_t0  = tcount;
                mask      = '0;
                npulses   = 0;
                act_ticks = 0;
                aborted   = 0;
                check(rise, "R5 burst opens with pulse", int'(rise), 1);
                if (last_start >= 0)
                    check(tcount - last_start == BT, "R6 burst period",
                          tcount - last_start, BT);
                last_start = tcount;
                if (await_first) begin
                    check(tcount == ticks_at_en + 1, "R8 restart on first tick",
                          tcount - ticks_at_en, 1);
                    await_first = 0;
                end
            end
            if (rise) begin
                width = 0;
                if (burst_active) begin
                    int d;
                    d = tcount - burst_t0;
                    check((d % H == 0) && (d / H <= 32), "R3 pulse on half-slot grid", d, (d / H) * H);
                    if ((d % H == 0) && (d / H <= 32)) mask[d / H] = 1'b1;
                    npulses++;
                end
            end
            if (pulse_out && tick) width++;
            if (!pulse_out && prev_pulse)
                check(width == P, "R4 pulse width", width, P);
            if (burst_active && tick) act_ticks++;
            if (!burst_active && prev_act && !aborted) begin
                check(mask == exp_mask(exp_word), mid_change ? "R7 latched word" : "R2 burst content",
                      int'(mask[31:0]), int'(exp_mask(exp_word)));
                check(npulses == 17 + ones(exp_word), "R2 pulse count", npulses, 17 + ones(exp_word));
                check(act_ticks == 33 * H, "R5 burst length", act_ticks, 33 * H);
                mid_change = 0;
            end
            if (!enable) begin
                last_start = -1;
                if (burst_active) aborted = 1;
            end
            if (tick) tcount++;
        end
        prev_pulse = pulse_out;
        prev_act   = burst_active;
        prev_en    = enable;
        prev_cw    = code_word;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    task automatic run_burst(input logic [15:0] w, input bit change_mid);
        @(posedge clk); #1 code_word = w;
        @(posedge burst_active);
        if (change_mid) begin
            repeat (60) @(posedge clk);
            #1 code_word = ~w ^ 16'($urandom);
            mid_change = 1;
        end
        @(negedge burst_active);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!pulse_out && !burst_active, "R1 outputs during reset",
              int'({pulse_out, burst_active}), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!pulse_out && !burst_active, "R1 outputs after reset",
              int'({pulse_out, burst_active}), 0);
        mon_on = 1;
        @(posedge clk); #1 enable = 1'b1;

        run_burst(16'h0000, 0);
        run_burst(16'hFFFF, 0);
        run_burst(16'h0001, 0);
        run_burst(16'h8000, 0);
        run_burst(16'hA5C3, 1);
        for (int i = 0; i < 6; i++)
            run_burst(16'($urandom), (i % 2) == 1);

        // abort in the middle of a pulse
        @(posedge burst_active);
        repeat (40) @(posedge clk);
        while (!pulse_out) @(posedge clk);
        #1 enable = 1'b0;
        repeat (40) @(negedge clk);
        check(!pulse_out && !burst_active, "R8 quiet while disabled",
              int'({pulse_out, burst_active}), 0);
        @(posedge clk); #1 enable = 1'b1;
        run_burst(16'h3C5A, 0);
        run_burst(16'($urandom), 1);
        run_burst(16'h1248, 0);

        repeat (10) @(posedge clk);
        finish_run();
    end

endmodule